// File: doc/BRIEF.md
# Debug Data Trace Nibble Serializer

This block turns captured processor bus operands and taken-branch target addresses into a stream on a 4-bit debug data port, one nibble per clock. Each item goes out as a size marker nibble followed by its payload nibbles, lowest nibble first. A small queue absorbs bursts, so items can arrive faster than the port drains them.

Two control codes set what gets traced. The operand policy code picks no operands, writes only, reads only, or both. The branch code picks no target, the low 2 address bytes, or the low 3 bytes. Each code is sampled when an item is accepted, so a change affects only later items. A request that finds the queue full is lost and raises a sticky overflow flag.

Top module: `dbg_trace_ser`

## Requirements
- R1: While rst_ni is low and right after reset, nib_o is 0x0, nib_valid_o is 0 and ovf_o is 0.
- R2: Operand policy code data_ctl_i: 2'b00 accepts no operand, 2'b01 only writes (cap_write_i=1), 2'b10 only reads (cap_write_i=0), 2'b11 both. An operand that is not accepted causes no output.
- R3: An accepted operand emits its marker first: cap_size_i 2'b00 (byte) gives marker 0x8 and 2 data nibbles, 2'b01 (word) gives 0x9 and 4 nibbles, 2'b10 or 2'b11 (long) gives 0xA and 8 nibbles.
- R4: Payload nibbles leave least significant first, one per clock, taken from cap_data_i[3:0] upward (or br_addr_i[3:0] upward).
- R5: Branch code tgt_ctl_i: 2'b00 queues nothing for br_valid_i; 2'b01 emits marker 0xB and four nibbles of br_addr_i[15:0]; 2'b10 or 2'b11 emits 0xB and six nibbles of br_addr_i[23:0].
- R6: When cap_valid_i and br_valid_i are high in the same cycle and the operand is accepted, only the operand is queued; if the operand is not accepted, the branch is handled as in R5.
- R7: The queue holds 4 items besides the one being sent; a request accepted by R2/R5 while 4 items wait is dropped and ovf_o goes to 1 and stays 1 until reset.
- R8: Items are sent with the control codes that were in force in the cycle they were accepted; later code changes do not alter them.
- R9: With the port idle, nib_valid_o is 0 and nib_o is 0x0; an item accepted at a clock edge into an empty block shows its marker after the second edge, and queued items follow one another with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Trace clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_ctl_i | input | 2 | Operand capture policy code |
| tgt_ctl_i | input | 2 | Branch target byte count code |
| cap_valid_i | input | 1 | Operand capture request pulse |
| cap_write_i | input | 1 | 1 for a write access, 0 for a read |
| cap_size_i | input | 2 | Operand size: byte, word, long |
| cap_data_i | input | 32 | Operand data |
| br_valid_i | input | 1 | Taken-branch request pulse |
| br_addr_i | input | 32 | Branch target address |
| nib_o | output | 4 | Trace nibble |
| nib_valid_o | output | 1 | Trace nibble valid |
| ovf_o | output | 1 | Sticky queue overflow flag |

## Verification
Operands of all three sizes are sent under each policy code with both reads and writes, so a wrong size decode, nibble order or policy bit shows as a mismatched or unexpected nibble. Branches under each target code separate four-nibble from six-nibble truncation, and same-cycle operand and branch pulses with accepted and rejected operands show the precedence. A burst of six long operands fills the queue exactly, telling a correct depth and drop from an off-by-one, and code changes right after a request check that queued items keep their original form.

// File: rtl/dbg_trace_pkg.sv
package dbg_trace_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned LEN_W  = 4;

  localparam logic [NIB_W-1:0] MRK_BYTE = 4'h8;
  localparam logic [NIB_W-1:0] MRK_WORD = 4'h9;
  localparam logic [NIB_W-1:0] MRK_LONG = 4'hA;
  localparam logic [NIB_W-1:0] MRK_BRT  = 4'hB;

  typedef struct packed {
    logic [NIB_W-1:0]  marker;
    logic [LEN_W-1:0]  len;      // payload nibbles after marker
    logic [DATA_W-1:0] payload;
  } trace_item_t;
endpackage

// File: rtl/dbg_trace_filter.sv
module dbg_trace_filter
  import dbg_trace_pkg::*;
(
  input  logic [1:0]        data_ctl_i,
  input  logic [1:0]        tgt_ctl_i,
  input  logic              cap_valid_i,
  input  logic              cap_write_i,
  input  logic [1:0]        cap_size_i,
  input  logic [DATA_W-1:0] cap_data_i,
  input  logic              br_valid_i,
  input  logic [DATA_W-1:0] br_addr_i,
  output logic              push_o,
  output trace_item_t       item_o
);
  logic cap_ok, br_ok;

  assign cap_ok = cap_valid_i && (cap_write_i ? data_ctl_i[0] : data_ctl_i[1]);
  assign br_ok  = br_valid_i && (tgt_ctl_i != 2'b00);
  assign push_o = cap_ok || br_ok;

  always_comb begin
    item_o = '0;
    if (cap_ok) begin
      item_o.payload = cap_data_i;
      unique case (cap_size_i)
        2'b00:   begin item_o.marker = MRK_BYTE; item_o.len = LEN_W'(2); end
        2'b01:   begin item_o.marker = MRK_WORD; item_o.len = LEN_W'(4); end
        default: begin item_o.marker = MRK_LONG; item_o.len = LEN_W'(8); end
      endcase
    end else if (br_ok) begin
      item_o.marker  = MRK_BRT;
      item_o.payload = br_addr_i;
      item_o.len     = tgt_ctl_i[1] ? LEN_W'(6) : LEN_W'(4);
    end
  end
endmodule

// File: rtl/dbg_trace_fifo.sv
module dbg_trace_fifo
  import dbg_trace_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  trace_item_t      item_i,
  input  logic             pop_i,
  output trace_item_t      item_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o,
  output logic             drop_o
);
  trace_item_t      mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full_o  = (count_o == CNT_W'(DEPTH));
  assign empty_o = (count_o == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign drop_o  = push_i && full_o;
  assign item_o  = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      if (do_push && !do_pop)      count_o <= count_o + 1'b1;
      else if (do_pop && !do_push) count_o <= count_o - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= item_i;
  end
endmodule

// File: rtl/dbg_trace_shift.sv
module dbg_trace_shift
  import dbg_trace_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             avail_i,
  input  trace_item_t      item_i,
  output logic             pop_o,
  output logic [NIB_W-1:0] nib_o,
  output logic             nib_valid_o
);
  logic              busy;
  logic [LEN_W-1:0]  remain;
  logic [DATA_W-1:0] shreg;
  logic              done;

  // current nibble is the last of its item (or nothing is being sent)
  assign done  = !busy || (remain == '0);
  assign pop_o = done && avail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy        <= 1'b0;
      remain      <= '0;
      shreg       <= '0;
      nib_o       <= '0;
      nib_valid_o <= 1'b0;
    end else if (done) begin
      if (avail_i) begin
        busy        <= 1'b1;
        remain      <= item_i.len;
        shreg       <= item_i.payload;
        nib_o       <= item_i.marker;
        nib_valid_o <= 1'b1;
      end else begin
        busy        <= 1'b0;
        nib_o       <= '0;
        nib_valid_o <= 1'b0;
      end
    end else begin
      nib_o  <= shreg[NIB_W-1:0];
      shreg  <= shreg >> NIB_W;
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/dbg_trace_ser.sv
module dbg_trace_ser
  import dbg_trace_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        data_ctl_i,
  input  logic [1:0]        tgt_ctl_i,
  input  logic              cap_valid_i,
  input  logic              cap_write_i,
  input  logic [1:0]        cap_size_i,
  input  logic [DATA_W-1:0] cap_data_i,
  input  logic              br_valid_i,
  input  logic [DATA_W-1:0] br_addr_i,
  output logic [NIB_W-1:0]  nib_o,
  output logic              nib_valid_o,
  output logic              ovf_o
);
  trace_item_t      new_item, head_item;
  logic             push_req, q_empty, q_full, q_drop, q_pop;
  logic [CNT_W-1:0] q_count;

  dbg_trace_filter u_filter (
    .data_ctl_i  (data_ctl_i),
    .tgt_ctl_i   (tgt_ctl_i),
    .cap_valid_i (cap_valid_i),
    .cap_write_i (cap_write_i),
    .cap_size_i  (cap_size_i),
    .cap_data_i  (cap_data_i),
    .br_valid_i  (br_valid_i),
    .br_addr_i   (br_addr_i),
    .push_o      (push_req),
    .item_o      (new_item)
  );

  dbg_trace_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_req),
    .item_i  (new_item),
    .pop_i   (q_pop),
    .item_o  (head_item),
    .empty_o (q_empty),
    .full_o  (q_full),
    .count_o (q_count),
    .drop_o  (q_drop)
  );

  dbg_trace_shift u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .avail_i     (!q_empty),
    .item_i      (head_item),
    .pop_o       (q_pop),
    .nib_o       (nib_o),
    .nib_valid_o (nib_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ovf_o <= 1'b0;
    else if (q_drop) ovf_o <= 1'b1;
  end
endmodule

// File: rtl/dbg_trace_ser_chk.sv
module dbg_trace_ser_chk #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       data_ctl_i,
  input logic             cap_valid_i,
  input logic             br_valid_i,
  input logic [3:0]       nib_o,
  input logic             nib_valid_o,
  input logic             ovf_o,
  input logic             push_req,
  input logic [CNT_W-1:0] q_count
);
  AST_CTL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_valid_i && data_ctl_i == 2'b00 && !br_valid_i) |-> !push_req); // R2
  AST_MARKER_LEADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nib_valid_o) |-> nib_o[3]); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count <= CNT_W'(DEPTH)); // R7
  AST_OVF_ON_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req && q_count == CNT_W'(DEPTH)) |=> ovf_o); // R7
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R7
  AST_IDLE_NIBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nib_valid_o |-> nib_o == 4'h0); // R9
endmodule

bind dbg_trace_ser dbg_trace_ser_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .data_ctl_i  (data_ctl_i),
  .cap_valid_i (cap_valid_i),
  .br_valid_i  (br_valid_i),
  .nib_o       (nib_o),
  .nib_valid_o (nib_valid_o),
  .ovf_o       (ovf_o),
  .push_req    (push_req),
  .q_count     (q_count)
);

// File: tb/dbg_trace_ser_tb.sv
module dbg_trace_ser_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  data_ctl_i = 2'b11;
  logic [1:0]  tgt_ctl_i = 2'b00;
  logic        cap_valid_i = 1'b0;
  logic        cap_write_i = 1'b0;
  logic [1:0]  cap_size_i = 2'b00;
  logic [31:0] cap_data_i = '0;
  logic        br_valid_i = 1'b0;
  logic [31:0] br_addr_i = '0;
  logic [3:0]  nib_o;
  logic        nib_valid_o;
  logic        ovf_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [3:0] exp_q[$];
  int         tag_q[$];

  always #5 clk_i = ~clk_i;

  dbg_trace_ser u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_ctl_i(data_ctl_i), .tgt_ctl_i(tgt_ctl_i),
    .cap_valid_i(cap_valid_i), .cap_write_i(cap_write_i), .cap_size_i(cap_size_i),
    .cap_data_i(cap_data_i), .br_valid_i(br_valid_i), .br_addr_i(br_addr_i),
    .nib_o(nib_o), .nib_valid_o(nib_valid_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_item(input int tag, input logic [3:0] mrk, input int len,
                             input logic [31:0] pay);
    exp_q.push_back(mrk); tag_q.push_back(tag);
    for (int i = 0; i < len; i++) begin
      exp_q.push_back(pay[4*i +: 4]); tag_q.push_back(tag);
    end
  endtask

  function automatic bit cap_accept(input logic wr);
    return wr ? data_ctl_i[0] : data_ctl_i[1];
  endfunction

  task automatic model_cap(input int tag, input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'b00:   expect_item(tag, 4'h8, 2, d);
      2'b01:   expect_item(tag, 4'h9, 4, d);
      default: expect_item(tag, 4'hA, 8, d);
    endcase
  endtask

  task automatic model_br(input int tag, input logic [31:0] a);
    if (tgt_ctl_i != 2'b00) expect_item(tag, 4'hB, tgt_ctl_i[1] ? 6 : 4, a);
  endtask

  // one-cycle request; keep=0 marks a request the model expects to be dropped
  task automatic cap(input int tag, input logic wr, input logic [1:0] sz,
                     input logic [31:0] d, input bit keep);
    cap_valid_i = 1'b1; cap_write_i = wr; cap_size_i = sz; cap_data_i = d;
    if (keep && cap_accept(wr)) model_cap(tag, sz, d);
    @(negedge clk_i);
    cap_valid_i = 1'b0;
  endtask

  task automatic br(input int tag, input logic [31:0] a);
    br_valid_i = 1'b1; br_addr_i = a;
    model_br(tag, a);
    @(negedge clk_i);
    br_valid_i = 1'b0;
  endtask

  task automatic both(input int tag, input logic wr, input logic [1:0] sz,
                      input logic [31:0] d, input logic [31:0] a);
    cap_valid_i = 1'b1; cap_write_i = wr; cap_size_i = sz; cap_data_i = d;
    br_valid_i = 1'b1; br_addr_i = a;
    if (cap_accept(wr)) model_cap(tag, sz, d);
    else model_br(tag, a);
    @(negedge clk_i);
    cap_valid_i = 1'b0; br_valid_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && nib_valid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2/R5 unexpected nibble actual %0h expected none", nib_o);
      end else begin
        automatic logic [3:0] e = exp_q.pop_front();
        automatic int t = tag_q.pop_front();
        if (nib_o !== e) begin
          errors++;
          $display("FAIL R%0d nibble actual %0h expected %0h", t, nib_o, e);
        end
      end
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <100000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 nib during reset", nib_o, 0);
    chk("R1 valid during reset", nib_valid_o, 0);
    chk("R1 ovf during reset", ovf_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 valid after reset", nib_valid_o, 0);
    chk("R9 idle nibble", nib_o, 0);

    // R9 latency: marker after second edge
    cap(9, 1'b1, 2'b00, 32'h0000_005C, 1'b1);
    chk("R9 not yet valid", nib_valid_o, 0);
    @(negedge clk_i);
    chk("R9 marker latency", {nib_valid_o, nib_o}, 5'h18);
    drain();

    // R3 R4 all sizes, both directions, policy 11
    cap(3, 1'b1, 2'b00, 32'hDEAD_BEA7, 1'b1);
    cap(3, 1'b0, 2'b01, 32'h1234_5678, 1'b1);
    cap(4, 1'b1, 2'b10, 32'h89AB_CDEF, 1'b1);
    cap(4, 1'b0, 2'b11, 32'hF0E1_D2C3, 1'b1);
    drain();

    // R2 policy codes
    data_ctl_i = 2'b01;
    cap(2, 1'b0, 2'b10, 32'h1111_2222, 1'b1);
    cap(2, 1'b1, 2'b01, 32'h0000_ABCD, 1'b1);
    drain();
    data_ctl_i = 2'b10;
    cap(2, 1'b1, 2'b10, 32'h3333_4444, 1'b1);
    cap(2, 1'b0, 2'b00, 32'h0000_0096, 1'b1);
    drain();
    data_ctl_i = 2'b00;
    cap(2, 1'b1, 2'b10, 32'h5555_6666, 1'b1);
    cap(2, 1'b0, 2'b10, 32'h7777_8888, 1'b1);
    drain();
    chk("R2 off leaves port idle", nib_valid_o, 0);

    // R5 branch codes
    data_ctl_i = 2'b11;
    tgt_ctl_i = 2'b00;
    br(5, 32'hCAFE_F00D);
    drain();
    tgt_ctl_i = 2'b01;
    br(5, 32'h00AB_CD12);
    tgt_ctl_i = 2'b10;
    br(5, 32'h0076_5432);
    tgt_ctl_i = 2'b11;
    br(5, 32'hFF9A_8B7C);
    drain();

    // R6 precedence
    tgt_ctl_i = 2'b11;
    both(6, 1'b1, 2'b01, 32'h0000_4321, 32'h00EE_DDCC);
    data_ctl_i = 2'b10;
    both(6, 1'b1, 2'b01, 32'h0000_4321, 32'h00BB_AA99);
    drain();

    // R8 code changes after queuing
    data_ctl_i = 2'b11; tgt_ctl_i = 2'b01;
    cap(8, 1'b1, 2'b10, 32'h0102_0304, 1'b1);
    br(8, 32'h0013_5724);
    tgt_ctl_i = 2'b11; data_ctl_i = 2'b00;
    drain();
    data_ctl_i = 2'b11;

    // R7 overflow: six longs back to back, sixth is dropped
    chk("R7 ovf clear before burst", ovf_o, 0);
    for (int i = 0; i < 6; i++)
      cap(7, 1'b0, 2'b10, 32'hA000_0000 + 32'(i * 32'h0101_0101), i < 5);
    chk("R7 ovf set on drop", ovf_o, 1);
    drain();
    chk("R7 ovf sticky", ovf_o, 1);
    cap(7, 1'b1, 2'b00, 32'h0000_0042, 1'b1);
    drain();
    chk("R7 ovf still set", ovf_o, 1);

    chk("R9 scoreboard empty", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule